// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Unit

This block drives an 8-bit output port from a pattern register that changes only on timing events. A 16-bit up counter runs against a programmable period. Each time it equals the period, it produces a compare event and restarts from zero, so events recur every PERIOD+1 clock cycles. Software, or a DMA-style agent that answers the per-event request pulse, places the next pattern in a staging register. The compare event then copies that pattern into the output register.

The copy is masked per bit. A bit whose enable is clear keeps the value it already has. The eight outputs form two 4-bit groups, and each group picks its own trigger source with a 2-bit selector: the internal compare event, or one of three compare events from outside the block. A typical use is stepper-motor phase sequencing. With the enable mask at 0xF8, feeding the ten patterns 0x80, 0xC0, 0x40, 0x60, 0x20, 0x30, 0x10, 0x18, 0x08, 0x88 in a loop yields five-phase alternating one- and two-phase excitation on the top five outputs.

The register write port decodes a 3-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | period | 16-bit compare value |
| 1 | control | bit0 run, bit1 interrupt enable, bits[3:2] lower-group source, bits[5:4] upper-group source |
| 2 | staging | 8-bit pattern for the next transfer |
| 3 | bit enables | 8-bit transfer mask |
| 4 | status | writing 1 to bit0 clears the interrupt flag |

Top module: `pulse_pattern_unit`

## Requirements
- R1: After reset, `pat_out`, `irq` and `dreq` are all 0.
- R2: With control bit0 (run) set and period P, a compare event occurs every P+1 cycles and the counter restarts from zero. `dreq` is high for exactly one cycle after each event, and the first event comes P+1 cycles after the write that sets run.
- R3: On a trigger selected by its group, each enabled output bit takes the value of the corresponding staging bit at the clock edge that ends the compare cycle.
- R4: Output bits whose enable (address 3) is 0 keep their current value when a trigger occurs.
- R5: A write to the staging register (address 2) never changes `pat_out` directly. The output register resets to 0. If the staging register is not rewritten between two triggers, the same value is transferred again.
- R6: Selector code 0 picks the internal compare event, and codes 1 to 3 pick `ext_match[code-1]`. A group whose selector is not 0 is not updated by the internal compare event.
- R7: When control bit1 is set, a compare event sets `irq`. The flag stays set until a write to address 4 with bit0 = 1, and a write with bit0 = 0 leaves it set. With control bit1 clear, a compare event does not set `irq`.
- R8: With the enable mask at 0xF8, staging 0x80 loaded before start, and each following pattern of the ten-step sequence written after each event, `pat_out` steps through 0x80, 0xC0, 0x40, 0x60, 0x20, 0x30, 0x10, 0x18, 0x08, 0x88 and then repeats.
- R9: While run is 0 the counter holds at zero, and no compare event, `dreq` pulse or internal-triggered output change occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| ext_match | input | 3 | Compare events from other timers, one-cycle pulses |
| pat_out | output | 8 | Pattern output port |
| irq | output | 1 | Sticky compare interrupt flag |
| dreq | output | 1 | One-cycle request pulse per compare event |

## Verification
The assertions assume that `ext_match` pulses and register writes are synchronous to `clk` and hold steady across each edge. They also assume the period is not lowered below the current count while the counter runs, because the counter would then wrap through its full range. The stimulus drives every input on the falling edge and writes the period only while the counter is stopped or still at zero. It also keeps the period at 4 so that event edges can be counted exactly.

// File: rtl/ptn_pkg.sv
package ptn_pkg;

  // register map of the write port
  typedef enum logic [2:0] {
    ADR_PERIOD = 3'd0,
    ADR_CTRL   = 3'd1,
    ADR_STAGE  = 3'd2,
    ADR_ENABLE = 3'd3,
    ADR_STATUS = 3'd4
  } ptn_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IEN_BIT = 1;
  localparam int CTRL_SEL_LSB = 2;

  // masked transfer: enabled bits take the new value, others keep the old
  function automatic logic [31:0] masked_load(input logic [31:0] cur,
                                              input logic [31:0] nxt,
                                              input logic [31:0] en);
    return (cur & ~en) | (nxt & en);
  endfunction

  // interval counter step: clear on match or when stopped
  function automatic logic [31:0] count_step(input logic        run,
                                             input logic [31:0] cnt,
                                             input logic [31:0] period);
    if (!run || cnt == period) return 32'd0;
    return cnt + 32'd1;
  endfunction

endpackage

// File: rtl/ptn_regs.sv
module ptn_regs #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int CTRL_W = 6,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              cmp_evt,
  output logic [CNT_W-1:0]  period_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] enable_q,
  output logic              irq_q
);
  import ptn_pkg::*;

  logic irq_clr_w;
  logic irq_set_w;
  ptn_addr_e addr_w;

  assign addr_w    = ptn_addr_e'(wr_addr);
  assign irq_clr_w = wr_en && addr_w == ADR_STATUS && wr_data[0];
  assign irq_set_w = cmp_evt && ctrl_q[CTRL_IEN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      ctrl_q   <= '0;
      stage_q  <= '0;
      enable_q <= '0;
    end else if (wr_en) begin
      case (addr_w)
        ADR_PERIOD: period_q <= wr_data[CNT_W-1:0];
        ADR_CTRL:   ctrl_q   <= wr_data[CTRL_W-1:0];
        ADR_STAGE:  stage_q  <= wr_data[DATA_W-1:0];
        ADR_ENABLE: enable_q <= wr_data[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  // set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (irq_set_w) irq_q <= 1'b1;
    else if (irq_clr_w) irq_q <= 1'b0;
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr_w |=> irq_q);
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt && ctrl_q[CTRL_IEN_BIT] |=> irq_q);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && !(cmp_evt && ctrl_q[CTRL_IEN_BIT]) |=> !irq_q);

endmodule

// File: rtl/ptn_timer.sv
module ptn_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cmp_evt
);
  import ptn_pkg::*;

  logic [31:0] next_w;

  assign cmp_evt = run && (cnt_q == period);
  assign next_w  = count_step(run, 32'(cnt_q), 32'(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_w[CNT_W-1:0];
  end

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cnt_q == '0);
  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cmp_evt |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/ptn_group.sv
module ptn_group #(
  parameter int GW     = 4,
  parameter int SEL_W  = 2,
  localparam int NSRC  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GW-1:0]    stage,
  input  logic [GW-1:0]    enable,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  src_evt,
  output logic [GW-1:0]    q
);
  import ptn_pkg::*;

  logic        hit_w;
  logic [31:0] merged_w;

  assign hit_w    = src_evt[sel];
  assign merged_w = masked_load(32'(q), 32'(stage), 32'(enable));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (hit_w) q <= merged_w[GW-1:0];
  end

  a_r5_no_trigger_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_w |=> $stable(q));
  a_r3_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w && (&enable) |=> q == $past(stage));

  for (genvar b = 0; b < GW; b++) begin : g_bit
    a_r4_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !enable[b] |=> $stable(q[b]));
  end

endmodule

// File: rtl/pulse_pattern_unit.sv
module pulse_pattern_unit #(
  parameter int DATA_W = 8,
  parameter int GRP_W  = 4,
  parameter int SEL_W  = 2,
  parameter int CNT_W  = 16,
  parameter int BUS_W  = 16,
  localparam int NGRP  = DATA_W / GRP_W,
  localparam int NSRC  = 1 << SEL_W,
  localparam int CTRL_W = 2 + SEL_W * NGRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [NSRC-2:0]   ext_match,
  output logic [DATA_W-1:0] pat_out,
  output logic              irq,
  output logic              dreq
);
  import ptn_pkg::*;

  logic [CNT_W-1:0]  period_w;
  logic [CTRL_W-1:0] ctrl_w;
  logic [DATA_W-1:0] stage_w;
  logic [DATA_W-1:0] enable_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              cmp_evt;
  logic [NSRC-1:0]   src_evt;
  logic              dreq_q;

  ptn_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CTRL_W(CTRL_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_evt(cmp_evt), .period_q(period_w), .ctrl_q(ctrl_w), .stage_q(stage_w),
    .enable_q(enable_w), .irq_q(irq)
  );

  ptn_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(ctrl_w[CTRL_RUN_BIT]), .period(period_w),
    .cnt_q(cnt_w), .cmp_evt(cmp_evt)
  );

  // source 0 is the internal compare, sources 1.. are external events
  assign src_evt = {ext_match, cmp_evt};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    ptn_group #(.GW(GRP_W), .SEL_W(SEL_W)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .stage(stage_w[g*GRP_W +: GRP_W]),
      .enable(enable_w[g*GRP_W +: GRP_W]),
      .sel(ctrl_w[CTRL_SEL_LSB + g*SEL_W +: SEL_W]),
      .src_evt(src_evt),
      .q(pat_out[g*GRP_W +: GRP_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreq_q <= 1'b0;
    else        dreq_q <= cmp_evt;
  end
  assign dreq = dreq_q;

  a_r2_request_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> dreq);
  a_r9_stopped_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_w[CTRL_RUN_BIT] && !cmp_evt |=> !dreq);
  a_r5_stage_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_evt && ext_match == '0 |=> $stable(pat_out));

endmodule

// File: tb/test_pulse_pattern_unit.sv
module test_pulse_pattern_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  ext_match = '0;
  logic [7:0]  pat_out;
  logic        irq;
  logic        dreq;

  int checks = 0;
  int errors = 0;

  pulse_pattern_unit i_pulse_pattern_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_match(ext_match), .pat_out(pat_out), .irq(irq), .dreq(dreq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(input logic run, input logic ien,
                                       input logic [1:0] sel_lo, input logic [1:0] sel_hi);
    return {10'd0, sel_hi, sel_lo, ien, run};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pat_out", 32'(pat_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 dreq", 32'(dreq), 32'h0);
  endtask

  task automatic t_interval();
    int pulses = 0;
    int doubles = 0;
    logic prev = 1'b0;
    do_reset();
    wr(3'd0, 16'd4);
    wr(3'd1, ctrl(1, 0, 0, 0));
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (dreq) pulses++;
      if (dreq && prev) doubles++;
      prev = dreq;
    end
    check("R2 dreq pulses in 20 cycles", 32'(pulses), 32'd4);
    check("R2 dreq single-cycle", 32'(doubles), 32'd0);
    wr(3'd1, ctrl(0, 0, 0, 0));
    tick(1);
    pulses = 0;
    wr(3'd2, 16'h00FF);
    wr(3'd3, 16'h00FF);
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (dreq) pulses++;
    end
    check("R9 no dreq while stopped", 32'(pulses), 32'd0);
    check("R9 output unchanged while stopped", 32'(pat_out), 32'h0);
  endtask

  task automatic t_mask();
    do_reset();
    wr(3'd0, 16'd4);
    wr(3'd3, 16'h00FF);
    wr(3'd2, 16'h00A5);
    wr(3'd1, ctrl(1, 0, 0, 0));
    tick(4);
    check("R2 no change before first event", 32'(pat_out), 32'h0);
    tick(1);
    check("R3 full transfer", 32'(pat_out), 32'hA5);
    wr(3'd3, 16'h000F);
    wr(3'd2, 16'h005A);
    tick(3);
    check("R4 disabled bits hold", 32'(pat_out), 32'hAA);
  endtask

  task automatic t_stage();
    do_reset();
    wr(3'd0, 16'd4);
    wr(3'd3, 16'h00FF);
    wr(3'd2, 16'h0011);
    wr(3'd1, ctrl(1, 0, 0, 0));
    tick(2);
    wr(3'd2, 16'h0022);
    check("R5 stage write not visible", 32'(pat_out), 32'h0);
    tick(2);
    check("R5 latest staged value sent", 32'(pat_out), 32'h22);
    wr(3'd2, 16'h0033);
    tick(1);
    check("R5 stage write mid-interval", 32'(pat_out), 32'h22);
    tick(3);
    check("R5 new value at next event", 32'(pat_out), 32'h33);
    tick(5);
    check("R5 same value resent", 32'(pat_out), 32'h33);
  endtask

  task automatic t_select();
    do_reset();
    wr(3'd0, 16'd4);
    wr(3'd3, 16'h00FF);
    wr(3'd2, 16'h00C3);
    wr(3'd1, ctrl(1, 0, 2'd0, 2'd1));
    tick(5);
    check("R6 only timer-selected group updates", 32'(pat_out), 32'h03);
    wr(3'd1, ctrl(0, 0, 2'd0, 2'd1));
    ext_match = 3'b010; tick(1); ext_match = 3'b000; tick(1);
    check("R6 unselected source ignored", 32'(pat_out), 32'h03);
    ext_match = 3'b001; tick(1); ext_match = 3'b000; tick(1);
    check("R6 external source updates upper group", 32'(pat_out), 32'hC3);
  endtask

  task automatic t_irq();
    do_reset();
    wr(3'd0, 16'd4);
    wr(3'd1, ctrl(1, 0, 0, 0));
    tick(5);
    check("R7 no irq when disabled", 32'(irq), 32'h0);
    wr(3'd1, ctrl(1, 1, 0, 0));
    tick(4);
    check("R7 irq set on event", 32'(irq), 32'h1);
    wr(3'd1, ctrl(0, 1, 0, 0));
    tick(3);
    check("R7 irq sticky", 32'(irq), 32'h1);
    wr(3'd4, 16'h0000);
    check("R7 write 0 keeps irq", 32'(irq), 32'h1);
    wr(3'd4, 16'h0001);
    check("R7 write 1 clears irq", 32'(irq), 32'h0);
  endtask

  task automatic t_sequence();
    logic [7:0] seq [10] = '{8'h80, 8'hC0, 8'h40, 8'h60, 8'h20,
                             8'h30, 8'h10, 8'h18, 8'h08, 8'h88};
    do_reset();
    wr(3'd0, 16'd4);
    wr(3'd3, 16'h00F8);
    wr(3'd2, 16'(seq[0]));
    wr(3'd1, ctrl(1, 0, 0, 0));
    tick(5);
    for (int k = 0; k < 12; k++) begin
      check($sformatf("R8 step %0d", k), 32'(pat_out), 32'(seq[k % 10]));
      wr(3'd2, 16'(seq[(k + 1) % 10]));
      tick(4);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_interval();
    t_mask();
    t_stage();
    t_select();
    t_irq();
    t_sequence();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule